// File: doc/BRIEF.md
# Parallel Single-Slope Conversion Sequencer

This block is the digital half of a many-channel single-slope converter. One shared tick counter runs while an external ramp rises, and every channel watches its own comparator. When a channel's comparator first goes high, the block stores the ramp position for that channel as a 10-bit code. A channel whose comparator never rises during the ramp is given full scale. All channels convert at once, so adding a channel costs only a synchronizer, an edge detector and one code register.

A conversion starts with a one-cycle request. The block raises the ramp-run control for exactly 2^CW cycles and keeps sampling for a few more cycles so that late comparator edges can pass through the synchronizer. It then raises the done flag and presents the codes one channel per cycle on a shared output bus, in ascending channel order. The analogue ramp and comparators sit outside the block.

Top module: `multi_ramp_adc`

## Requirements
- R1: After a synchronous reset, ramp_run_o, done_o and code_valid_o are all 0.
- R2: A start_i sampled high while idle makes ramp_run_o go high in the next cycle (cycle 0) and stay high for exactly 2^CW cycles (cycles 0 to 1023 at default parameters).
- R3: A channel's code equals the index j of the first cycle, counted from cycle 0, in which its comparator input is sampled high, for j from 0 to 2^CW-1. The two-stage synchronizer delay is removed from the code.
- R4: A channel whose comparator shows no low-to-high transition during cycles 0 to 2^CW-1 gets code 2^CW-1 (1023). This includes a comparator held high from before the start.
- R5: Only the first rising edge in a conversion is captured. Later toggles of the same comparator leave the code unchanged.
- R6: done_o is 0 in cycles 0 to 1025 and goes high in cycle 2^CW+2 (1026). It stays high until the next accepted start.
- R7: From cycle 2^CW+3 (1027), code_valid_o is high for NCH consecutive cycles. code_ch_o runs 0, 1, ..., NCH-1 over those cycles and code_o carries that channel's code. code_valid_o then returns to 0.
- R8: A start_i raised while a conversion or its readout is in progress is ignored. The ramp window, done timing and codes are those of the run already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | NCH | Per-channel comparator outputs (asynchronous) |
| ramp_run_o | output | 1 | High while the shared ramp must rise |
| done_o | output | 1 | Conversion finished, codes available |
| code_valid_o | output | 1 | code_o and code_ch_o hold a result |
| code_ch_o | output | $clog2(NCH) | Channel index of the presented code |
| code_o | output | CW | Presented conversion code |

## Verification
Every timing is counted from the clock edge that accepts start_i, and that edge begins cycle 0. ramp_run_o is due high in cycles 0 to 1023. done_o is due in cycle 1026. The readout codes are due in cycles 1027 to 1030. A comparator edge driven in cycle j must come out as code j, even though it passes through two synchronizer flops and an edge detector and is latched two cycles later. The bench drives inputs and samples outputs on the falling edge of every cycle of a run, and compares each output against the value the requirements give for that cycle index. Stray start requests during the ramp and during readout are placed at fixed cycle indices.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } conv_state_t;
endpackage

// File: rtl/ramp_seq.sv
module ramp_seq
  import ssc_pkg::*;
#(
  parameter int CW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          read_last_i,
  output logic [CW:0]   tick_o,
  output logic          arm_o,
  output logic          cap_en_o,
  output logic          read_en_o,
  output logic          ramp_run_o,
  output logic          done_o
);
  localparam int TICKS = 1 << CW;
  localparam logic [CW:0] RAMP_END = (CW+1)'(TICKS - 1);
  localparam logic [CW:0] LAST     = (CW+1)'(TICKS - 1 + SYNC);

  conv_state_t state;
  logic [CW:0] tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tick       <= '0;
      ramp_run_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state      <= ST_CONV;
            tick       <= '0;
            ramp_run_o <= 1'b1;
            done_o     <= 1'b0;
          end
        end
        ST_CONV: begin
          tick <= tick + 1'b1;
          if (tick == RAMP_END) ramp_run_o <= 1'b0;
          if (tick == LAST) begin
            state  <= ST_READ;
            done_o <= 1'b1;
          end
        end
        ST_READ: begin
          if (read_last_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tick_o    = tick;
  assign arm_o     = (state == ST_IDLE) && start_i;
  assign cap_en_o  = (state == ST_CONV);
  assign read_en_o = (state == ST_READ);

  // R2: the ramp control only ever runs inside a conversion
  a_r2_ramp_in_conv: assert property (@(posedge clk) disable iff (rst)
    ramp_run_o |-> (state == ST_CONV));
  // R8: a start seen mid-conversion does not restart the counter
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && start_i && tick != LAST) |=> (state == ST_CONV && tick == $past(tick) + 1'b1));
  // R6: done only rises on entering readout
  a_r6_done_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (state == ST_READ));
  // R3: the tick counter never runs past the sampling window
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |-> (tick <= LAST));
endmodule

// File: rtl/chan_capture.sv
module chan_capture #(
  parameter int CW   = 10,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_i,
  input  logic          arm_i,
  input  logic          cap_en_i,
  input  logic [CW:0]   tick_i,
  output logic [CW-1:0] code_o
);
  localparam logic [CW:0] OFS = (CW+1)'(SYNC);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            captured;
  logic            rise;
  logic [CW:0]     adj;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cmp_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] && !prev_q;
  assign adj  = (tick_i >= OFS) ? (tick_i - OFS) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o   <= '1;
      captured <= 1'b0;
    end else if (arm_i) begin
      code_o   <= '1;
      captured <= 1'b0;
    end else if (cap_en_i && rise && !captured) begin
      code_o   <= adj[CW-1:0];
      captured <= 1'b1;
    end
  end

  // R5: once a code is taken it holds until the next start
  a_r5_single_capture: assert property (@(posedge clk) disable iff (rst)
    (captured && !arm_i) |=> $stable(code_o));
  // R4: arming presets full scale
  a_r4_preset_full: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (code_o == '1 && !captured));
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
  parameter int NCH = 4,
  parameter int CW  = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [NCH*CW-1:0] codes_i,
  output logic              last_o,
  output logic              valid_o,
  output logic [CHW-1:0]    ch_o,
  output logic [CW-1:0]     code_o
);
  localparam logic [CHW-1:0] TOP = CHW'(NCH - 1);

  logic [CW-1:0]  arr [NCH];
  logic [CHW-1:0] idx;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign arr[g] = codes_i[g*CW +: CW];
  end

  assign last_o = en_i && (idx == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      valid_o <= 1'b0;
      ch_o    <= '0;
      code_o  <= '0;
    end else if (en_i) begin
      valid_o <= 1'b1;
      ch_o    <= idx;
      code_o  <= arr[idx];
      idx     <= (idx == TOP) ? '0 : idx + 1'b1;
    end else begin
      valid_o <= 1'b0;
      idx     <= '0;
    end
  end

  // R7: readout begins with channel 0
  a_r7_first_channel: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> (ch_o == '0));
  // R7: channels follow in ascending order without gaps
  a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ch_o != TOP) |=> (valid_o && ch_o == $past(ch_o) + 1'b1));
endmodule

// File: rtl/multi_ramp_adc.sv
module multi_ramp_adc #(
  parameter int NCH  = 4,
  parameter int CW   = 10,
  parameter int SYNC = 2,
  parameter int CHW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [NCH-1:0] cmp_i,
  output logic           ramp_run_o,
  output logic           done_o,
  output logic           code_valid_o,
  output logic [CHW-1:0] code_ch_o,
  output logic [CW-1:0]  code_o
);
  logic [CW:0]       tick;
  logic              arm, cap_en, read_en, read_last;
  logic [NCH*CW-1:0] codes;

  ramp_seq #(.CW(CW), .SYNC(SYNC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .read_last_i (read_last),
    .tick_o      (tick),
    .arm_o       (arm),
    .cap_en_o    (cap_en),
    .read_en_o   (read_en),
    .ramp_run_o  (ramp_run_o),
    .done_o      (done_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_capture #(.CW(CW), .SYNC(SYNC)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .cmp_i    (cmp_i[c]),
      .arm_i    (arm),
      .cap_en_i (cap_en),
      .tick_i   (tick),
      .code_o   (codes[c*CW +: CW])
    );
  end

  result_shifter #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .en_i    (read_en),
    .codes_i (codes),
    .last_o  (read_last),
    .valid_o (code_valid_o),
    .ch_o    (code_ch_o),
    .code_o  (code_o)
  );

  // R1: nothing is presented while the ramp runs
  a_r1_quiet_during_ramp: assert property (@(posedge clk) disable iff (rst)
    ramp_run_o |-> (!done_o && !code_valid_o));
endmodule

// File: tb/tb_multi_ramp_adc.sv
module tb_multi_ramp_adc;
  localparam int NCH = 4;
  localparam int CW  = 10;
  localparam int CHW = 2;
  localparam int FULL = (1 << CW) - 1;
  localparam int NEVER = 2047;
  localparam int PREHI = 2046;
  localparam int NV = 5;

  // [45] start during ramp, [44] start during readout, then ch3..ch0 rise cycles
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 11'd2047, 11'd512,  11'd1023, 11'd0},
    {1'b0, 1'b0, 11'd1024, 11'd2046, 11'd1022, 11'd1},
    {1'b1, 1'b0, 11'd900,  11'd7,    11'd100,  11'd100},
    {1'b0, 1'b1, 11'd2047, 11'd300,  11'd0,    11'd1023},
    {1'b0, 1'b0, 11'd2046, 11'd2046, 11'd2046, 11'd2046}
  };

  logic           clk = 1'b0;
  logic           rst;
  logic           start_i;
  logic [NCH-1:0] cmp_i;
  logic           ramp_run_o, done_o, code_valid_o;
  logic [CHW-1:0] code_ch_o;
  logic [CW-1:0]  code_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  multi_ramp_adc #(.NCH(NCH), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .ramp_run_o(ramp_run_o), .done_o(done_o), .code_valid_o(code_valid_o),
    .code_ch_o(code_ch_o), .code_o(code_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int v);
    int rise [NCH];
    int expc [NCH];
    int got  [NCH];
    int ramp_bad = 0, done_bad = 0, nvalid = 0, ord_bad = 0;
    for (int c = 0; c < NCH; c++) begin
      rise[c] = int'(VEC[v][c*11 +: 11]);
      expc[c] = (rise[c] <= FULL) ? rise[c] : FULL;
      got[c]  = -1;
      cmp_i[c] = (rise[c] == PREHI);
    end
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < 1026 + NCH + 3; j++) begin
      if (ramp_run_o !== (j < 1024)) ramp_bad++;
      if (done_o !== (j >= 1026)) done_bad++;
      if (code_valid_o) begin
        if (j < 1027 || j >= 1027 + NCH || int'(code_ch_o) != j - 1027) ord_bad++;
        else got[code_ch_o] = int'(code_o);
        nvalid++;
      end
      start_i = (VEC[v][45] && j == 500) || (VEC[v][44] && j == 1027);
      for (int c = 0; c < NCH; c++) begin
        if (rise[c] != PREHI && rise[c] != NEVER)
          cmp_i[c] = (j >= rise[c]) && !(j >= rise[c] + 3 && j < rise[c] + 6);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    cmp_i = '0;
    check(VEC[v][45] ? "R2/R8 ramp window with stray start" : "R2 ramp window", ramp_bad, 0);
    check(VEC[v][44] ? "R6/R8 done timing with stray start" : "R6 done timing", done_bad, 0);
    check("R7 valid count", nvalid, NCH);
    check("R7 channel order", ord_bad, 0);
    for (int c = 0; c < NCH; c++) begin
      if (rise[c] <= FULL) check("R3/R5 captured code", got[c], expc[c]);
      else check("R4 full scale code", got[c], expc[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    start_i = 1'b0;
    cmp_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset ramp_run_o", int'(ramp_run_o), 0);
    check("R1 reset done_o", int'(done_o), 0);
    check("R1 reset code_valid_o", int'(code_valid_o), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // directed: reset in the middle of a ramp clears the controls (R1)
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 ramp running before reset", int'(ramp_run_o), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset ramp_run_o", int'(ramp_run_o), 0);
    check("R1 mid-run reset done_o", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check("R1 stays idle after reset", int'(ramp_run_o), 0);

    // directed: a fresh run after the reset still converts correctly
    run_vec(0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule